// File: doc/BRIEF.md
# Descriptor Chain Fetch Sequencer

This block walks a linked list of transfer descriptors that software has placed in memory. Each descriptor is eight 32-bit words. The sequencer reads a descriptor one word at a time through a single-outstanding memory read port and loads the words into working registers. It then starts a data engine with the loaded source, destination, count and control values, waits for that engine to report completion, and follows the descriptor's next pointer to the following descriptor.

Software controls the sequencer through a small register port. It writes the first descriptor's address, sets the enable bit to start the walk, and polls a status word. The status word has an active flag and three sticky event flags: the chain reached a null pointer, a descriptor asking for an interrupt has completed, and a memory read returned an error. A stopped chain can be continued: a resume write makes the sequencer re-read the next-pointer word of the last descriptor it handled. If software has since linked a new descriptor there, the walk carries on.

Top module: `desc_chain_seq`

## Requirements
- R1: A descriptor at address A is fetched by reads of A, A+4, ... A+28 in that order. The words are, in order: next pointer, sources 1 to 4, destination, byte count and control. Source k appears on `engSrc[(k-1)*32 +: 32]`.
- R2: Bits 4:0 of a loaded next pointer and of a value written to the current-address register (offset 0x08) are forced to zero. A next pointer whose upper 27 bits are zero counts as null.
- R3: `engCount` carries bits 23:0 of the byte-count word. Bits 31:24 are discarded.
- R4: While idle, writing the control register (offset 0x00) with bit 0 = 1 when enable was 0 starts a fetch at the current address. Status bit 10 (active) reads 1 from the next cycle until the sequencer returns to idle.
- R5: After the eighth word arrives, `engStart` pulses for exactly one cycle. The engine outputs stay stable until `engDone`. No memory read is issued between `engStart` and `engDone`.
- R6: When a descriptor completes and its next pointer is null, status bit 8 (end of chain) is set and the sequencer goes idle.
- R7: When a descriptor completes, status bit 9 (end of transfer) is set if bit 0 of its control word is 1. It is left unchanged otherwise.
- R8: While idle, a control write with bits 1 and 0 both set re-reads word 0 of the current descriptor. A non-null value moves the current address to it and fetches that descriptor. A null value leaves the sequencer idle with no engine run and no flag change.
- R9: Status bits 5, 8 and 9 are cleared by writing 1 to them at offset 0x04. Writing 0 leaves them unchanged.
- R10: If enable is written to 0 while a descriptor is in progress, that descriptor still runs. The sequencer then goes idle without fetching further and without setting end of chain.
- R11: A read answered with `memErr` sets status bit 5 (master abort), ends the walk and issues no `engStart` for that descriptor.
- R12: Offset 0x08 reads the current descriptor address and offset 0x0C reads the loaded next pointer. Both are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational on regAddr) |
| memReq | output | 1 | Read request, held until memValid |
| memAddr | output | 32 | Read byte address |
| memValid | input | 1 | Read response strobe |
| memErr | input | 1 | Response is an error (valid with memValid) |
| memData | input | 32 | Read response data |
| engStart | output | 1 | One-cycle start pulse to the data engine |
| engSrc | output | 128 | Four source addresses, source 1 in the low word |
| engDst | output | 32 | Destination address |
| engCount | output | 24 | Byte count |
| engCtrl | output | 32 | Descriptor control word |
| engDone | input | 1 | Engine completion strobe |

## Verification
The bench builds chains whose next pointers and null terminators carry junk in bits 4:0. A design that failed to mask those bits would jump to a misaligned address or would miss the end of the chain. Count words with high bits set expose a missing 24-bit mask. Mixed interrupt bits show whether end of transfer is taken from the wrong descriptor. Resume is tried both after a link has been appended and against a still-null pointer. A wrong design would either ignore the new link or run a stale descriptor again. Enable is cleared while the first descriptor runs, and an error is injected in the middle of the second fetch. These catch a sequencer that keeps walking, drops the running descriptor, or starts the engine on a half-loaded descriptor.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int unsigned NUM_SRC        = 4;
  localparam int unsigned WORDS_PER_DESC = NUM_SRC + 4;
  localparam int unsigned IDX_W          = $clog2(WORDS_PER_DESC);
  localparam int unsigned ALIGN_BITS     = 5;
  localparam int unsigned COUNT_BITS     = 24;

  // word positions inside a descriptor
  localparam int unsigned W_NEXT  = 0;
  localparam int unsigned W_DST   = NUM_SRC + 1;
  localparam int unsigned W_COUNT = NUM_SRC + 2;
  localparam int unsigned W_CTRL  = NUM_SRC + 3;

  // register offsets
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_CUR  = 8'h08;
  localparam logic [7:0] OFS_NEXT = 8'h0C;

  // status bit positions
  localparam int unsigned SB_ABORT  = 5;
  localparam int unsigned SB_EOC    = 8;
  localparam int unsigned SB_EOT    = 9;
  localparam int unsigned SB_ACTIVE = 10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_START, ST_WAIT, ST_RESUME
  } seqState_t;

  typedef struct packed {
    logic             loadWord;
    logic [IDX_W-1:0] wordIdx;
    logic             advance;
    logic             hostSetCur;
  } dpStrobe_t;
endpackage

// File: rtl/dcs_datapath.sv
module dcs_datapath
  import dcs_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  dpStrobe_t                 stb,
  input  logic [ADDR_W-1:0]         hostData,
  input  logic [DATA_W-1:0]         memData,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [ADDR_W-1:0]         curAddr,
  output logic [ADDR_W-1:0]         nextAddr,
  output logic                      nextNull,
  output logic                      respNonNull,
  output logic [NUM_SRC*DATA_W-1:0] engSrc,
  output logic [ADDR_W-1:0]         engDst,
  output logic [COUNT_BITS-1:0]     engCount,
  output logic [DATA_W-1:0]         engCtrl
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1));

  logic [ADDR_W-1:0] respPtr;
  logic              loadNext;

  assign respPtr     = memData[ADDR_W-1:0] & ALIGN_MASK;
  assign respNonNull = |respPtr;
  assign nextNull    = ~|nextAddr;
  assign loadNext    = stb.loadWord && (stb.wordIdx == IDX_W'(W_NEXT));
  assign memAddr     = curAddr + {{(ADDR_W-IDX_W-2){1'b0}}, stb.wordIdx, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curAddr <= '0;
    end else if (stb.hostSetCur) begin
      curAddr <= hostData & ALIGN_MASK;
    end else if (stb.advance) begin
      curAddr <= loadNext ? respPtr : nextAddr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nextAddr <= '0;
      engSrc   <= '0;
      engDst   <= '0;
      engCount <= '0;
      engCtrl  <= '0;
    end else if (stb.loadWord) begin
      if (loadNext) nextAddr <= respPtr;
      for (int i = 0; i < int'(NUM_SRC); i++) begin
        if (stb.wordIdx == IDX_W'(i + 1)) engSrc[i*DATA_W +: DATA_W] <= memData;
      end
      if (stb.wordIdx == IDX_W'(W_DST))   engDst   <= memData[ADDR_W-1:0];
      if (stb.wordIdx == IDX_W'(W_COUNT)) engCount <= memData[COUNT_BITS-1:0];
      if (stb.wordIdx == IDX_W'(W_CTRL))  engCtrl  <= memData;
    end
  end
endmodule

// File: rtl/dcs_control.sv
module dcs_control
  import dcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       regWrEn,
  input  logic [7:0] regAddr,
  input  logic [1:0] wrCtrlBits,
  input  logic [2:0] wrClearBits,  // {eot, eoc, abort}
  input  logic       memValid,
  input  logic       memErr,
  input  logic       respNonNull,
  input  logic       nextNull,
  input  logic       descIrqEn,
  input  logic       engDone,
  output dpStrobe_t  stb,
  output logic       memReq,
  output logic       engStart,
  output logic       enable,
  output logic       flagAbort,
  output logic       flagEoc,
  output logic       flagEot,
  output logic       active
);
  seqState_t        state;
  logic [IDX_W-1:0] wordIdx;
  logic             ctrlWrite, statWrite, respOk, respBad, descDone;
  logic             setAbort, setEoc, setEot;

  assign ctrlWrite = regWrEn && (regAddr == OFS_CTRL);
  assign statWrite = regWrEn && (regAddr == OFS_STAT);
  assign memReq    = (state == ST_FETCH) || (state == ST_RESUME);
  assign engStart  = (state == ST_START);
  assign active    = (state != ST_IDLE);
  assign respOk    = memReq && memValid && !memErr;
  assign respBad   = memReq && memValid && memErr;
  assign descDone  = (state == ST_WAIT) && engDone;

  assign setAbort = respBad;
  assign setEoc   = descDone && nextNull;
  assign setEot   = descDone && descIrqEn;

  always_comb begin
    stb            = '0;
    stb.loadWord   = respOk;
    stb.wordIdx    = wordIdx;
    stb.advance    = (descDone && !nextNull && enable) ||
                     ((state == ST_RESUME) && respOk && respNonNull);
    stb.hostSetCur = regWrEn && (regAddr == OFS_CUR) && (state == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
      enable  <= 1'b0;
    end else begin
      if (ctrlWrite) enable <= wrCtrlBits[0];
      case (state)
        ST_IDLE: begin
          wordIdx <= '0;
          if (ctrlWrite && wrCtrlBits[0]) begin
            if (wrCtrlBits[1])  state <= ST_RESUME;
            else if (!enable)   state <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (respBad) begin
            state <= ST_IDLE;
          end else if (respOk) begin
            if (wordIdx == IDX_W'(WORDS_PER_DESC - 1)) state <= ST_START;
            else wordIdx <= wordIdx + 1'b1;
          end
        end
        ST_START: state <= ST_WAIT;
        ST_WAIT: begin
          if (engDone) begin
            wordIdx <= '0;
            state   <= stb.advance ? ST_FETCH : ST_IDLE;
          end
        end
        ST_RESUME: begin
          if (respBad) state <= ST_IDLE;
          else if (respOk) state <= respNonNull ? ST_FETCH : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // sticky flags: set wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagAbort <= 1'b0;
      flagEoc   <= 1'b0;
      flagEot   <= 1'b0;
    end else begin
      flagAbort <= setAbort || (flagAbort && !(statWrite && wrClearBits[0]));
      flagEoc   <= setEoc   || (flagEoc   && !(statWrite && wrClearBits[1]));
      flagEot   <= setEot   || (flagEot   && !(statWrite && wrClearBits[2]));
    end
  end
endmodule

// File: rtl/desc_chain_seq.sv
module desc_chain_seq
  import dcs_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      regWrEn,
  input  logic [7:0]                regAddr,
  input  logic [31:0]               regWrData,
  output logic [31:0]               regRdData,
  output logic                      memReq,
  output logic [ADDR_W-1:0]         memAddr,
  input  logic                      memValid,
  input  logic                      memErr,
  input  logic [DATA_W-1:0]         memData,
  output logic                      engStart,
  output logic [NUM_SRC*DATA_W-1:0] engSrc,
  output logic [ADDR_W-1:0]         engDst,
  output logic [COUNT_BITS-1:0]     engCount,
  output logic [DATA_W-1:0]         engCtrl,
  input  logic                      engDone
);
  dpStrobe_t         stb;
  logic [ADDR_W-1:0] curAddr, nextAddr;
  logic              nextNull, respNonNull, enable;
  logic              flagAbort, flagEoc, flagEot, seqActive;
  logic [31:0]       statusWord;

  dcs_control u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .regWrEn(regWrEn), .regAddr(regAddr),
    .wrCtrlBits(regWrData[1:0]),
    .wrClearBits({regWrData[SB_EOT], regWrData[SB_EOC], regWrData[SB_ABORT]}),
    .memValid(memValid), .memErr(memErr),
    .respNonNull(respNonNull), .nextNull(nextNull),
    .descIrqEn(engCtrl[0]), .engDone(engDone),
    .stb(stb), .memReq(memReq), .engStart(engStart), .enable(enable),
    .flagAbort(flagAbort), .flagEoc(flagEoc), .flagEot(flagEot),
    .active(seqActive)
  );

  dcs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .hostData(regWrData[ADDR_W-1:0]), .memData(memData),
    .memAddr(memAddr), .curAddr(curAddr), .nextAddr(nextAddr),
    .nextNull(nextNull), .respNonNull(respNonNull),
    .engSrc(engSrc), .engDst(engDst), .engCount(engCount), .engCtrl(engCtrl)
  );

  always_comb begin
    statusWord            = '0;
    statusWord[SB_ABORT]  = flagAbort;
    statusWord[SB_EOC]    = flagEoc;
    statusWord[SB_EOT]    = flagEot;
    statusWord[SB_ACTIVE] = seqActive;
    case (regAddr)
      OFS_CTRL: regRdData = {31'b0, enable};
      OFS_STAT: regRdData = statusWord;
      OFS_CUR:  regRdData = 32'(curAddr);
      OFS_NEXT: regRdData = 32'(nextAddr);
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/desc_chain_seq_chk.sv
module desc_chain_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        memReq,
  input logic        memValid,
  input logic        memErr,
  input logic [31:0] memAddr,
  input logic        engStart,
  input logic        engDone,
  input logic [31:0] engDst,
  input logic [23:0] engCount,
  input logic        active
);
  // R1: a pending read holds its address word-aligned until answered
  assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && !memValid |=> memReq && $stable(memAddr));
  assert_word_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> memAddr[1:0] == 2'b00);
  // R5: single-cycle start, no fetch while the engine owns the descriptor
  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    engStart |=> !engStart && !memReq);
  assert_desc_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active && !memReq && $past(active && !memReq) |-> $stable(engDst) && $stable(engCount));
  // R10: no reads once idle
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !memReq && !engStart);
  // R11: error response ends the walk without an engine start
  assert_abort_halts_R11: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && memValid && memErr |=> !active && !engStart);
endmodule

bind desc_chain_seq desc_chain_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .memReq(memReq), .memValid(memValid),
  .memErr(memErr), .memAddr(memAddr), .engStart(engStart), .engDone(engDone),
  .engDst(engDst), .engCount(engCount), .active(seqActive)
);

// File: tb/tb_desc_chain_seq.sv
`timescale 1ns/1ps
module tb_desc_chain_seq;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         regWrEn = 1'b0;
  logic [7:0]   regAddr = 8'h00;
  logic [31:0]  regWrData = '0, regRdData;
  logic         memReq, memValid = 1'b0, memErr = 1'b0, engStart, engDone = 1'b0;
  logic [31:0]  memAddr, memData = '0, engDst, engCtrl;
  logic [127:0] engSrc;
  logic [23:0]  engCount;

  always #4 clk = ~clk;

  desc_chain_seq dut (.*);

  int checks = 0, fails = 0;
  logic [31:0] mem [0:255];
  logic [31:0] errAddr = 32'hFFFF_FFFF;
  int engLat = 2, engRuns = 0, memWait = 0, engWait = -1;
  logic [127:0] logSrc [0:63];
  logic [31:0]  logDst [0:63], logCtrl [0:63];
  logic [23:0]  logCount [0:63];

  // memory responder
  always @(posedge clk) begin
    if (memValid) begin
      memValid <= 1'b0; memErr <= 1'b0; memWait <= 0;
    end else if (memReq) begin
      if (memWait >= int'($urandom_range(2, 0))) begin
        memValid <= 1'b1;
        memErr   <= (memAddr == errAddr);
        memData  <= mem[memAddr[9:2]];
      end else memWait <= memWait + 1;
    end
  end

  // data engine model
  always @(posedge clk) begin
    engDone <= 1'b0;
    if (engStart) begin
      logSrc[engRuns & 63] <= engSrc; logDst[engRuns & 63] <= engDst;
      logCount[engRuns & 63] <= engCount; logCtrl[engRuns & 63] <= engCtrl;
      engRuns <= engRuns + 1;
      engWait <= engLat;
    end else if (engWait == 0) begin
      engDone <= 1'b1; engWait <= -1;
    end else if (engWait > 0) engWait <= engWait - 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2000; i++) begin
      regRead(8'h04, s);
      if (!s[10]) break;
    end
  endtask

  // slot s lives at byte address s*32; nextSlot 0 means null (with junk low bits)
  task automatic buildDesc(input int s, input int nextSlot, input logic ie);
    mem[s*8] = (nextSlot * 32) | ($urandom & 31);
    for (int w = 1; w < 7; w++) mem[s*8 + w] = $urandom | 32'h0100_0000;
    mem[s*8 + 7] = {$urandom & 32'hFFFF_FFFE} | {31'b0, ie};
  endtask

  // expected engine view of slot s (R1 word order, R3 count mask)
  function automatic logic [127:0] expSrc(input int s);
    return {mem[s*8+4], mem[s*8+3], mem[s*8+2], mem[s*8+1]};
  endfunction

  task automatic checkRun(input string req, input int run, input int s);
    chk({req, " src1-2"}, logSrc[run][31:0] ^ logSrc[run][63:32], mem[s*8+1] ^ mem[s*8+2]);
    chk({req, " src1"}, logSrc[run][31:0], expSrc(s)[31:0]);
    chk({req, " src4"}, logSrc[run][127:96], expSrc(s)[127:96]);
    chk({req, " dst"}, logDst[run], mem[s*8+5]);
    chk("R3 count", {8'h0, logCount[run]}, mem[s*8+6] & 32'h00FF_FFFF);
    chk({req, " ctrl"}, logCtrl[run], mem[s*8+7]);
  endtask

  initial begin
    logic [31:0] r;
    int base, n, slots[4];
    logic anyIe;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk); rst_n = 1'b1;

    // reset state
    regRead(8'h04, r); chk("R4 reset status", r, 32'h0);
    regRead(8'h08, r); chk("R12 reset cur", r, 32'h0);
    regRead(8'h0C, r); chk("R12 reset next", r, 32'h0);
    chk("R5 reset outputs", {30'b0, memReq, engStart}, 32'h0);

    // directed chain 1 -> 2 -> 3, junk low bits everywhere
    buildDesc(1, 2, 1'b0); buildDesc(2, 3, 1'b1); buildDesc(3, 0, 1'b0);
    regWrite(8'h08, 32'h0000_0033);
    regRead(8'h08, r); chk("R2 cur write masked", r, 32'h20);
    base = engRuns;
    regWrite(8'h00, 32'h1);
    regRead(8'h04, r); chk("R4 active after start", r & 32'h400, 32'h400);
    waitIdle();
    chk("R6 run count", engRuns - base, 3);
    checkRun("R1 d1", base, 1); checkRun("R1 d2", base + 1, 2); checkRun("R1 d3", base + 2, 3);
    regRead(8'h04, r); chk("R6 R7 status after chain", r, 32'h300);
    regRead(8'h08, r); chk("R12 cur = last", r, 32'h60);
    regRead(8'h0C, r); chk("R2 R12 null next", r, 32'h0);

    // write-one-to-clear
    regWrite(8'h04, 32'h100);
    regRead(8'h04, r); chk("R9 clear eoc only", r, 32'h200);
    regWrite(8'h04, 32'h0);
    regRead(8'h04, r); chk("R9 zero write keeps", r, 32'h200);
    regWrite(8'h04, 32'h220);
    regRead(8'h04, r); chk("R9 clear eot", r, 32'h0);

    // resume onto an appended descriptor
    buildDesc(4, 0, 1'b1);
    mem[3*8] = 32'h80 | 32'h5;
    base = engRuns;
    regWrite(8'h00, 32'h3);
    waitIdle();
    chk("R8 resume runs one", engRuns - base, 1);
    checkRun("R8 resumed", base, 4);
    regRead(8'h08, r); chk("R8 cur moved", r, 32'h80);
    regRead(8'h04, r); chk("R8 R7 status", r, 32'h300);

    // resume against a null pointer
    regWrite(8'h04, 32'h320);
    base = engRuns;
    regWrite(8'h00, 32'h3);
    waitIdle();
    repeat (10) @(negedge clk);
    chk("R8 null resume no run", engRuns - base, 0);
    regRead(8'h04, r); chk("R8 null resume flags", r, 32'h0);
    regRead(8'h08, r); chk("R8 null resume cur", r, 32'h80);

    // disable while first descriptor runs
    buildDesc(5, 6, 1'b0); buildDesc(6, 7, 1'b0); buildDesc(7, 0, 1'b0);
    regWrite(8'h00, 32'h0);
    regWrite(8'h08, 32'hA0);
    engLat = 20; base = engRuns;
    regWrite(8'h00, 32'h1);
    for (int i = 0; i < 500 && engRuns == base; i++) @(negedge clk);
    regWrite(8'h00, 32'h0);
    waitIdle(); engLat = 2;
    repeat (10) @(negedge clk);
    chk("R10 one run", engRuns - base, 1);
    regRead(8'h04, r); chk("R10 no eoc", r, 32'h0);
    regRead(8'h08, r); chk("R10 cur stays", r, 32'hA0);
    regRead(8'h0C, r); chk("R12 next readback", r, 32'hC0);

    // error in the middle of the second fetch
    errAddr = 32'hC0 + 32'h8;
    base = engRuns;
    regWrite(8'h00, 32'h1);
    waitIdle();
    repeat (5) @(negedge clk);
    chk("R11 one run", engRuns - base, 1);
    regRead(8'h04, r); chk("R11 abort flag", r, 32'h20);
    errAddr = 32'hFFFF_FFFF;
    regWrite(8'h04, 32'h20);
    regRead(8'h04, r); chk("R9 R11 abort cleared", r, 32'h0);

    // random chains
    for (int it = 0; it < 5; it++) begin
      n = int'($urandom_range(4, 1)); anyIe = 1'b0;
      for (int k = 0; k < n; k++) slots[k] = 8 + it * 4 + k;
      for (int k = 0; k < n; k++) begin
        logic ie = 1'($urandom);
        anyIe |= ie;
        buildDesc(slots[k], (k == n - 1) ? 0 : slots[k+1], ie);
      end
      regWrite(8'h04, 32'h320);
      regWrite(8'h00, 32'h0);
      regWrite(8'h08, 32'(slots[0] * 32) | ($urandom & 31));
      base = engRuns;
      regWrite(8'h00, 32'h1);
      waitIdle();
      chk("R6 random run count", engRuns - base, n);
      for (int k = 0; k < n; k++) checkRun("R1 random", base + k, slots[k]);
      regRead(8'h04, r); chk("R7 random status", r, {22'b0, anyIe, 9'h100});
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule